// File: doc/BRIEF.md
# Run-Length Waveform Transmitter Channel

This block plays back a pulse train that is stored as a list of run-length entries in a small local memory. Each entry gives an output level and a duration. The duration counts ticks of a divided clock. The channel reads the memory through a combinational read port and drives its output pin at each entry's level for that entry's length. It then moves on to the next entry with no dead cycle between entries. An entry with zero duration is a terminator. In one-shot mode the terminator ends playback and sets a sticky done flag. In continuous mode the terminator sends playback back to the first entry. When no playback is running, the pin shows a programmed idle level and a programmed output enable.

Long sequences can be streamed through the small memory. With wrap enabled, the read position continues from entry 0 after the last entry of the memory. A threshold flag goes up each time a programmed number of entries has been loaded, which tells the feeder when it can refill the part of the memory already played out.

The control sequence is a three-state machine. **IDLE** waits for start, and the transition *IDLE→LOAD* is *go*. **LOAD** fetches the entry at the read position: *LOAD→SEND* is *accept* (a valid entry), *LOAD→LOAD* is *rewind* (a terminator in continuous mode), and *LOAD→IDLE* is *finish* (a terminator in one-shot mode). **SEND** holds the level. In the last cycle of an entry it fetches ahead. *SEND→SEND* is *chain* (the next entry is valid), *SEND→LOAD* is *rewind*, and *SEND→IDLE* is *finish*.

Top module: `pulse_train_tx`

## Requirements
- R1: After reset the channel is idle, the read position is entry 0 (mem_addr = 0), and both done_flag and thr_flag are 0.
- R2: While idle, tx_out equals idle_lvl and tx_oe equals idle_oe. While a playback runs (LOAD or SEND), tx_oe is 1.
- R3: Each 32-bit memory word holds two entries, and bits 15:0 are played before bits 31:16. In an entry, bit 15 is the level and bits 14:0 are the duration. Start is sampled at a clock edge. The first entry's level appears after the next edge. An entry with duration D holds its level for exactly D·max(div_f,1) cycles, and the next entry follows with no gap.
- R4: In one-shot mode, a terminator (duration 0) ends playback at the edge after the last cycle of the previous entry. From that edge the pin is idle and done_flag is 1.
- R5: With wrap_en = 0, the position past the last memory entry acts as a terminator. With wrap_en = 1, the entry after the last one is entry 0.
- R6: In continuous mode, a terminator causes one rewind cycle in which the previous level is held. Entry 0 follows in the next cycle, and this repeats for as long as cont_mode stays 1.
- R7: Each time `limit` entries have been loaded since start, thr_flag is set in the cycle in which that entry's level first appears. The count then restarts, so the event repeats. A limit of 0 never sets the flag.
- R8: done_flag and thr_flag stay set until their clear inputs are raised. A set in the same cycle as a clear takes priority.
- R9: A start with no rd_rst continues from the current read position, which after a one-shot finish is the terminator, so playback ends at once. rd_rst while idle returns the position to entry 0.
- R10: Start is ignored while a playback is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin playback from the current position (taken only when idle) |
| rd_rst | input | 1 | Return the read position to entry 0 (taken only when idle) |
| cont_mode | input | 1 | 1: a terminator rewinds to entry 0; 0: a terminator ends playback |
| wrap_en | input | 1 | 1: wrap past the last memory entry to entry 0 |
| div_f | input | DIV_W | Clock divider for duration ticks (0 acts as 1) |
| limit | input | LIM_W | Entries per threshold event (0 disables) |
| idle_lvl | input | 1 | Pin level while idle |
| idle_oe | input | 1 | Pin output enable while idle |
| clr_done | input | 1 | Clear done_flag |
| clr_thr | input | 1 | Clear thr_flag |
| mem_addr | output | AW | Word address of the memory read port |
| mem_data | input | 32 | Read data for mem_addr, valid in the same cycle |
| tx_out | output | 1 | Waveform output |
| tx_oe | output | 1 | Waveform output enable |
| done_flag | output | 1 | Sticky playback-finished flag |
| thr_flag | output | 1 | Sticky entry-threshold flag |

## Verification
Any error in the read position or in the remaining-tick counter shows up on tx_out as a level that arrives one entry early or late. It can also show up as a run of the wrong length, and this appears at the first entry boundary after the fault, which is at most D·div cycles later. The bench compares tx_out, tx_oe and both flags on every cycle against a trace that it builds from the memory contents. A slipped pointer or a wrong wrap, rewind or terminator decision therefore fails at the first cycle where it matters. A miscounted threshold shows up as a flag pulse on the wrong entry. The bench holds the clear input high so that each event appears as a single-cycle pulse.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int WORD_W = 32;
    localparam int ENT_W  = 16;
    localparam int DUR_W  = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEND = 2'd2
    } ptx_state_e;

    typedef struct packed {
        logic             lvl;
        logic [DUR_W-1:0] dur;
    } ptx_entry_t;

endpackage

// File: rtl/ptx_tick_div.sv
module ptx_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] top;

    assign top  = (div == '0) ? '0 : div - 1'b1;
    assign tick = en && (pre_q == top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (clr)     pre_q <= '0;
        else if (en)      pre_q <= tick ? '0 : pre_q + 1'b1;
    end

    // R3: with a divider above 1, ticks are never on consecutive cycles
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !clr && div > 1 && $stable(div) |=> !tick);

endmodule

// File: rtl/ptx_rd_ptr.sv
module ptx_rd_ptr #(
    parameter int N_ENT = 16,
    parameter int PW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          to_zero,
    input  logic          wrap_en,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(N_ENT - 1);
    localparam logic [PW-1:0] PAST = PW'(N_ENT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr <= '0;
        else if (to_zero)    ptr <= '0;
        else if (advance) begin
            if (ptr == LAST) ptr <= wrap_en ? '0 : PAST;
            else             ptr <= ptr + 1'b1;
        end
    end

    // R5: the position never goes beyond the past-end code
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PAST);

    // R5: with wrap, leaving the last entry lands on entry 0
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !to_zero && wrap_en && ptr == LAST |=> ptr == '0);

endmodule

// File: rtl/ptx_thresh.sv
module ptx_thresh #(
    parameter int LIM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LIM_W-1:0] limit,
    output logic             hit
);
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + 1'b1;
    assign hit    = inc && (limit != '0) && (cnt_nx == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (inc)     cnt_q <= hit ? '0 : cnt_nx;
    end

    // R7: after an event the count restarts, so a limit above 1 cannot fire twice in a row
    p_hit_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit && limit > 1 && $stable(limit) |=> !hit);

endmodule

// File: rtl/pulse_train_tx.sv
module pulse_train_tx #(
    parameter int MEM_WORDS = 8,
    parameter int LIM_W     = 9,
    parameter int DIV_W     = 8,
    localparam int N_ENT    = 2 * MEM_WORDS,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int PW       = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_rst,
    input  logic              cont_mode,
    input  logic              wrap_en,
    input  logic [DIV_W-1:0]  div_f,
    input  logic [LIM_W-1:0]  limit,
    input  logic              idle_lvl,
    input  logic              idle_oe,
    input  logic              clr_done,
    input  logic              clr_thr,
    output logic [AW-1:0]     mem_addr,
    input  logic [31:0]       mem_data,
    output logic              tx_out,
    output logic              tx_oe,
    output logic              done_flag,
    output logic              thr_flag
);
    import ptx_pkg::*;

    ptx_state_e             state, nxt;
    logic [PW-1:0]          ptr;
    ptx_entry_t             ent;
    logic [DUR_W-1:0]       rem_q;
    logic                   lvl_q;
    logic                   tick, hit;
    logic                   past_end, ent_ok, fetch;
    logic                   go, load_e, rewind, finish;

    // ---- memory read and entry decode ----
    assign mem_addr = ptr[AW:1];
    assign past_end = (ptr == PW'(N_ENT));
    assign ent      = ptr[0] ? ptx_entry_t'(mem_data[31:16]) : ptx_entry_t'(mem_data[15:0]);
    assign ent_ok   = !past_end && (ent.dur != '0);

    // ---- transition conditions ----
    assign go     = (state == ST_IDLE) && start;
    assign fetch  = (state == ST_LOAD) ||
                    ((state == ST_SEND) && tick && (rem_q == DUR_W'(1)));
    assign load_e = fetch && ent_ok;
    assign rewind = fetch && !ent_ok && cont_mode;
    assign finish = fetch && !ent_ok && !cont_mode;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = go ? ST_LOAD : ST_IDLE;
            ST_LOAD: nxt = load_e ? ST_SEND : (rewind ? ST_LOAD : ST_IDLE);
            ST_SEND: begin
                if (rewind)      nxt = ST_LOAD;
                else if (finish) nxt = ST_IDLE;
                else             nxt = ST_SEND;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // ---- output and datapath registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= 1'b0;
            rem_q     <= '0;
            done_flag <= 1'b0;
            thr_flag  <= 1'b0;
        end else begin
            if (go)          lvl_q <= idle_lvl;
            else if (load_e) lvl_q <= ent.lvl;

            if (load_e)      rem_q <= ent.dur;
            else if (tick)   rem_q <= rem_q - 1'b1;

            if (finish)        done_flag <= 1'b1;
            else if (clr_done) done_flag <= 1'b0;

            if (hit)           thr_flag <= 1'b1;
            else if (clr_thr)  thr_flag <= 1'b0;
        end
    end

    assign tx_out = (state == ST_IDLE) ? idle_lvl : lvl_q;
    assign tx_oe  = (state == ST_IDLE) ? idle_oe  : 1'b1;

    // ---- submodules ----
    ptx_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_SEND),
        .clr   (load_e),
        .div   (div_f),
        .tick  (tick)
    );

    ptx_rd_ptr #(.N_ENT(N_ENT), .PW(PW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (load_e),
        .to_zero (rewind || ((state == ST_IDLE) && rd_rst)),
        .wrap_en (wrap_en),
        .ptr     (ptr)
    );

    ptx_thresh #(.LIM_W(LIM_W)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .inc   (load_e),
        .limit (limit),
        .hit   (hit)
    );

    // R3: the remaining-tick count is never zero while a level is being held
    p_send_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEND |-> rem_q != '0);

    // R4: the done flag only rises as the channel reaches idle
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> state == ST_IDLE);

    // R10: a start during SEND does not move the machine out of SEND by itself
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEND && start && !fetch |=> state == ST_SEND);

endmodule

// File: tb/pulse_train_tx_tb_top.sv
`timescale 1ns/1ps
module pulse_train_tx_tb_top;

    localparam int MW   = 8;
    localparam int NE   = 2 * MW;
    localparam int MAXN = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 0, rd_rst = 0, cont_mode = 0, wrap_en = 0;
    logic [7:0]  div_f = 8'd1;
    logic [8:0]  limit = '0;
    logic        idle_lvl = 0, idle_oe = 0, clr_done = 0, clr_thr = 0;
    logic [2:0]  mem_addr;
    logic [31:0] mem_data;
    logic        tx_out, tx_oe, done_flag, thr_flag;

    logic [31:0] mem [0:MW-1];
    assign mem_data = mem[mem_addr];

    always #2 clk = ~clk;

    pulse_train_tx #(.MEM_WORDS(MW), .LIM_W(9), .DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_rst(rd_rst),
        .cont_mode(cont_mode), .wrap_en(wrap_en), .div_f(div_f), .limit(limit),
        .idle_lvl(idle_lvl), .idle_oe(idle_oe), .clr_done(clr_done), .clr_thr(clr_thr),
        .mem_addr(mem_addr), .mem_data(mem_data), .tx_out(tx_out), .tx_oe(tx_oe),
        .done_flag(done_flag), .thr_flag(thr_flag)
    );

    int checks = 0;
    int errors = 0;
    int model_ptr = 0;
    bit finished = 0;
    bit exp_lvl  [MAXN];
    bit exp_oe   [MAXN];
    bit exp_done [MAXN];
    bit exp_thr  [MAXN];

    function automatic logic [15:0] get_entry(int p);
        logic [31:0] w;
        w = mem[p / 2];
        return (p % 2 == 1) ? w[31:16] : w[15:0];
    endfunction

    function automatic logic [15:0] mk(bit lvl, int dur);
        return {lvl, 15'(dur)};
    endfunction

    task automatic check1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Builds the expected per-sample trace from the requirements (sample 0 = cycle after start edge)
    task automatic build_model(int n, bit cont, bit wrap, int div, int lim, bit hold_thr);
        int t = 1;
        int p = model_ptr;
        int cnt = 0;
        int dv = (div == 0) ? 1 : div;
        bit thr = 0;
        bit last = idle_lvl;
        exp_lvl[0] = idle_lvl; exp_oe[0] = 1; exp_done[0] = 0; exp_thr[0] = 0;
        while (t < n) begin
            logic [15:0] e;
            bit ok;
            e  = (p < NE) ? get_entry(p) : 16'h0;
            ok = (p < NE) && (e[14:0] != 0);
            if (ok) begin
                bit h;
                h = (lim != 0) && (cnt + 1 == lim);
                cnt = h ? 0 : cnt + 1;
                p = (p == NE - 1) ? (wrap ? 0 : NE) : p + 1;
                for (int c = 0; c < int'(e[14:0]) * dv && t < n; c++) begin
                    bit hh;
                    hh = (c == 0) && h;
                    thr = hold_thr ? hh : (thr | hh);
                    exp_lvl[t] = e[15]; exp_oe[t] = 1; exp_done[t] = 0; exp_thr[t] = thr;
                    t++;
                end
                last = e[15];
            end else if (cont) begin
                if (hold_thr) thr = 0;
                exp_lvl[t] = last; exp_oe[t] = 1; exp_done[t] = 0; exp_thr[t] = thr;
                p = 0;
                t++;
            end else begin
                if (hold_thr) thr = 0;
                for (int k = t; k < n; k++) begin
                    exp_lvl[k] = idle_lvl; exp_oe[k] = idle_oe; exp_done[k] = 1; exp_thr[k] = thr;
                end
                t = n;
            end
        end
        model_ptr = p;
    endtask

    task automatic run(string tag, int n, bit cont, bit wrap, int div, int lim,
                       bit hold_thr, bit poke);
        int bl = -1, bo = -1, bd = -1, bt = -1;
        logic al = 0, ao = 0, ad = 0, at = 0;
        @(negedge clk);
        cont_mode = cont; wrap_en = wrap; div_f = 8'(div); limit = 9'(lim);
        clr_done = 1; clr_thr = 1;
        @(negedge clk);
        clr_done = 0; clr_thr = hold_thr;
        build_model(n, cont, wrap, div, lim, hold_thr);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int t = 0; t < n; t++) begin
            if (t > 0) @(negedge clk);
            start = (poke && t == 5);
            if (bl < 0 && tx_out    !== exp_lvl[t])  begin bl = t; al = tx_out; end
            if (bo < 0 && tx_oe     !== exp_oe[t])   begin bo = t; ao = tx_oe; end
            if (bd < 0 && done_flag !== exp_done[t]) begin bd = t; ad = done_flag; end
            if (bt < 0 && thr_flag  !== exp_thr[t])  begin bt = t; at = thr_flag; end
        end
        start = 0; clr_thr = 0;
        checks += 4;
        if (bl >= 0) begin errors++; $display("FAIL %s tx_out t=%0d actual=%0b expected=%0b", tag, bl, al, exp_lvl[bl]); end
        if (bo >= 0) begin errors++; $display("FAIL %s tx_oe t=%0d actual=%0b expected=%0b", tag, bo, ao, exp_oe[bo]); end
        if (bd >= 0) begin errors++; $display("FAIL %s done t=%0d actual=%0b expected=%0b", tag, bd, ad, exp_done[bd]); end
        if (bt >= 0) begin errors++; $display("FAIL %s thr t=%0d actual=%0b expected=%0b", tag, bt, at, exp_thr[bt]); end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        model_ptr = 0;
    endtask

    task automatic pulse_rd_rst();
        @(negedge clk);
        rd_rst = 1;
        @(negedge clk);
        rd_rst = 0;
        model_ptr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < MW; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check1("R1 tx_out", tx_out, 1'b0);
        check1("R1 tx_oe", tx_oe, 1'b0);
        check1("R1 done_flag", done_flag, 1'b0);
        check1("R1 thr_flag", thr_flag, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check1("R1 mem_addr zero", mem_addr == 3'd0, 1'b1);

        // R2: idle pin follows programmed level and enable
        idle_lvl = 1; idle_oe = 1;
        @(negedge clk);
        check1("R2 idle level", tx_out, 1'b1);
        check1("R2 idle oe", tx_oe, 1'b1);
        idle_lvl = 0;
        @(negedge clk);
        check1("R2 idle level low", tx_out, 1'b0);

        // R3/R4: directed one-shot, lower half first, terminator at entry 4
        mem[0] = {mk(0, 5), mk(1, 3)};
        mem[1] = {mk(0, 1), mk(1, 2)};
        mem[2] = {mk(1, 7), mk(0, 0)};
        run("R3_R4 oneshot div1", 30, 0, 0, 1, 0, 0, 0);

        // R9: restart with no rd_rst sits on the terminator and ends at once
        run("R9 start at terminator", 6, 0, 0, 1, 0, 0, 0);
        pulse_rd_rst();
        // R3: divider of 3; R10: a start in the middle is ignored
        run("R3_R10 div3 poke", 50, 0, 0, 3, 0, 0, 1);
        pulse_rd_rst();
        // R3: divider value 0 acts as 1
        run("R3 div0", 20, 0, 0, 0, 0, 0, 0);
        pulse_rd_rst();
        // R7/R8: sticky threshold flag with limit 2
        run("R7_R8 sticky thr", 30, 0, 0, 1, 2, 0, 0);

        // R5: no wrap, the full memory ends at the past-end position
        for (int i = 0; i < MW; i++) mem[i] = {mk(i[0], 2), mk(~i[0], 1)};
        pulse_rd_rst();
        run("R5 end of memory", 70, 0, 0, 1, 0, 0, 0);

        // R5/R7/R8: wrap streaming, threshold pulses every 5 entries with clear held
        do_reset();
        run("R5_R7 wrap stream", 160, 0, 1, 2, 5, 1, 0);

        // R6: continuous mode with terminator at entry 3
        do_reset();
        mem[0] = {mk(0, 2), mk(1, 3)};
        mem[1] = {mk(0, 0), mk(1, 1)};
        run("R6 continuous", 80, 1, 0, 1, 4, 1, 0);
        do_reset();
        run("R6 continuous div2", 90, 1, 0, 2, 0, 0, 0);
        do_reset();

        // Constrained random one-shot playback
        for (int r = 0; r < 8; r++) begin
            int term;
            logic [15:0] ents [NE];
            term = $urandom_range(1, NE + 3);
            for (int e = 0; e < NE; e++)
                ents[e] = (e == term) ? 16'h0 : mk(1'($urandom_range(0, 1)), $urandom_range(1, 5));
            for (int w = 0; w < MW; w++) mem[w] = {ents[2*w+1], ents[2*w]};
            idle_lvl = 1'($urandom_range(0, 1));
            idle_oe  = 1'($urandom_range(0, 1));
            pulse_rd_rst();
            run("R3_R4_R5_R7 random", 300, 0, 0, $urandom_range(1, 3),
                $urandom_range(0, 4), 1'($urandom_range(0, 1)), 0);
        end

        // R2: after the last run the pin is idle again
        @(negedge clk);
        check1("R2 idle after run", tx_out, idle_lvl);
        check1("R2 oe after run", tx_oe, idle_oe);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule